// File: doc/BRIEF.md
# Crosspoint Control Serial Slave

This block is the configuration front end of a video crosspoint with twelve inputs and nine outputs. It receives write transactions over a two-wire I2C-compatible Standard-mode bus. SCL and SDA are sampled with a fast system clock, which also detects START and STOP conditions. The block accepts the device address byte only for the write address selected by a strap pin. It then takes a register pointer byte and a data byte, and loads the register that the pointer names. The bus is write-only, so a request to read is refused.

The stored settings drive decoded control outputs. For each output the block gives an enable, a two-bit gain code and a one-hot input selection. For each input it gives one bit that picks clamp or bias. The analog switches, clamps and amplifiers are outside this block and consume these signals directly.

Top module: `xpt_ctl_slave`

## Requirements
- R1: After reset every control output is 0 (all outputs off, no input routed, gain code 00, all inputs in bias mode) and SDA is not driven.
- R2: The slave acknowledges an address byte of 0x06 when `addr_sel` is 0 and 0x86 when `addr_sel` is 1. Any other address byte is not acknowledged, and the rest of that transaction is ignored.
- R3: An address byte whose R/W bit (bit 0) is 1 is not acknowledged. The slave then leaves SDA released and ignores every byte until the next START.
- R4: Once addressed, the slave acknowledges the pointer byte and the data byte by holding SDA low through the high phase of the ninth SCL pulse. SDA is released after the ninth pulse falls. Bytes are sent MSB first and sampled on SCL rising.
- R5: A data byte written to pointer 0x01+k (k = 0..8) sets output k+1. Bit 7 drives `out_en[k]` (1 = on), and bits 6:5 drive `out_gain[2k+1:2k]` (00 = 6 dB up to 11 = 9 dB).
- R6: Bits 4:0 of an output register select its input. Codes 1..12 set only bit k*12+(code-1) of `out_route`. Codes 0 and 13..31 route no input.
- R7: While an output's enable bit is 0, its 12-bit slice of `out_route` is all zeros, whatever its select field holds.
- R8: Pointer 0x1D loads `in_clamp[7:0]` from data bits 7:0. Pointer 0x1E loads `in_clamp[11:8]` from data bits 3:0 and ignores bits 7:4. A 1 selects clamp and a 0 selects bias.
- R9: A write to any pointer other than 0x01..0x09, 0x1D and 0x1E is acknowledged and changes no output.
- R10: Data bytes after the first data byte of a transaction are acknowledged and discarded.
- R11: A STOP before the data byte is complete leaves every register unchanged. A repeated START restarts address matching, and a pointer sent before it is forgotten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| addr_sel | input | 1 | Strap choosing which write address answers |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| out_en | output | 9 | Per-output enable |
| out_gain | output | 18 | Per-output gain code, two bits per output |
| out_route | output | 108 | Per-output one-hot input select, 12 bits per output |
| in_clamp | output | 12 | Per-input clamp (1) or bias (0) select |

## Verification
A register change is due four clock edges after SCL rises on the last bit of the data byte. Two edges pass through the synchronizer, the third registers the write strobe and the fourth loads the register. The bench applies its reference model at exactly that edge and compares every output on each falling clock edge. The acknowledge is due three edges after SCL falls on the eighth bit. The bench waits eight clocks of low time and then samples `sda_oe` in the middle of the ninth high phase, so the check falls well inside the window where the value must hold.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  // Where the byte engine is within one bit-level exchange.
  typedef enum logic [1:0] {
    PH_IDLE,   // released, waiting for START
    PH_BITS,   // shifting eight bits in
    PH_WAITF,  // byte taken, waiting for SCL fall to drive ACK
    PH_ACK     // driving ACK through the ninth pulse
  } phase_t;

  // Which byte of the write transaction is being received.
  typedef enum logic [1:0] {
    ST_DEV,
    ST_PTR,
    ST_DATA,
    ST_EXTRA
  } stage_t;

endpackage

// File: rtl/xpt_line_sync.sv
module xpt_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  // Idle bus is high, so the synchronizer resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  // SDA moving while SCL stays high is a bus condition, not data.
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/xpt_byte_engine.sv
module xpt_byte_engine
  import xpt_pkg::*;
#(
  parameter logic [6:0] DEV_LO = 7'h03,
  parameter logic [6:0] DEV_HI = 7'h43
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       addr_sel,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_ptr,
  output logic [7:0] wr_data
);

  phase_t     phase_q, phase_n;
  stage_t     stage_q, stage_n;
  logic [2:0] cnt_q,   cnt_n;
  logic [7:0] shreg_q, shreg_n;
  logic [7:0] ptr_q,   ptr_n;
  logic [7:0] wdat_q,  wdat_n;
  logic       oe_q,    oe_n;
  logic       wr_q,    wr_n;

  logic [7:0] byte_w;
  logic [7:0] dev_byte;

  assign byte_w   = {shreg_q[6:0], sda_s};
  assign dev_byte = {(addr_sel ? DEV_HI : DEV_LO), 1'b0};

  always_comb begin
    phase_n = phase_q;
    stage_n = stage_q;
    cnt_n   = cnt_q;
    shreg_n = shreg_q;
    ptr_n   = ptr_q;
    wdat_n  = wdat_q;
    oe_n    = oe_q;
    wr_n    = 1'b0;
    if (stop_det) begin
      phase_n = PH_IDLE;
      oe_n    = 1'b0;
    end else if (start_det) begin
      phase_n = PH_BITS;
      stage_n = ST_DEV;
      cnt_n   = 3'd0;
      oe_n    = 1'b0;
    end else begin
      unique case (phase_q)
        PH_BITS: begin
          if (scl_rise) begin
            shreg_n = byte_w;
            if (cnt_q == 3'd7) begin
              cnt_n = 3'd0;
              unique case (stage_q)
                ST_DEV:  phase_n = (byte_w == dev_byte) ? PH_WAITF : PH_IDLE;
                ST_PTR: begin
                  ptr_n   = byte_w;
                  phase_n = PH_WAITF;
                end
                ST_DATA: begin
                  wr_n    = 1'b1;
                  wdat_n  = byte_w;
                  phase_n = PH_WAITF;
                end
                default: phase_n = PH_WAITF;
              endcase
            end else begin
              cnt_n = cnt_q + 3'd1;
            end
          end
        end
        PH_WAITF: begin
          if (scl_fall) begin
            oe_n    = 1'b1;
            phase_n = PH_ACK;
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            oe_n    = 1'b0;
            phase_n = PH_BITS;
            stage_n = (stage_q == ST_EXTRA) ? ST_EXTRA : stage_t'(stage_q + 2'd1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      stage_q <= ST_DEV;
      cnt_q   <= '0;
      shreg_q <= '0;
      ptr_q   <= '0;
      wdat_q  <= '0;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_n;
      stage_q <= stage_n;
      cnt_q   <= cnt_n;
      shreg_q <= shreg_n;
      ptr_q   <= ptr_n;
      wdat_q  <= wdat_n;
      oe_q    <= oe_n;
      wr_q    <= wr_n;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_en   = wr_q;
  assign wr_ptr  = ptr_q;
  assign wr_data = wdat_q;

endmodule

// File: rtl/xpt_cfg_regs.sv
module xpt_cfg_regs #(
  parameter int         NUM_IN     = 12,
  parameter int         NUM_OUT    = 9,
  parameter logic [7:0] OUT_BASE   = 8'h01,
  parameter logic [7:0] CLAMP_BASE = 8'h1D
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [7:0]                wr_ptr,
  input  logic [7:0]                wr_data,
  output logic [NUM_OUT-1:0]        out_en,
  output logic [2*NUM_OUT-1:0]      out_gain,
  output logic [NUM_OUT*NUM_IN-1:0] out_route,
  output logic [NUM_IN-1:0]         in_clamp
);

  localparam int CLAMP_BYTES = (NUM_IN + 7) / 8;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    localparam logic [7:0] REG_ADDR = 8'(OUT_BASE + o);
    logic [7:0] ctl_q;
    logic       hit;

    assign hit = wr_en && (wr_ptr == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ctl_q <= '0;
      else if (hit) ctl_q <= wr_data;
    end

    assign out_en[o]         = ctl_q[7];
    assign out_gain[2*o +: 2] = ctl_q[6:5];

    // Codes with no input behind them decode to nothing.
    for (genvar i = 0; i < NUM_IN; i++) begin : g_sel
      localparam logic [4:0] CODE = 5'(i + 1);
      assign out_route[o*NUM_IN + i] = ctl_q[7] && (ctl_q[4:0] == CODE);
    end
  end

  for (genvar k = 0; k < CLAMP_BYTES; k++) begin : g_clamp
    localparam int         LO       = 8 * k;
    localparam int         W        = ((NUM_IN - LO) < 8) ? (NUM_IN - LO) : 8;
    localparam logic [7:0] REG_ADDR = 8'(CLAMP_BASE + k);
    logic [W-1:0] clamp_q;
    logic         hit;

    assign hit = wr_en && (wr_ptr == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   clamp_q <= '0;
      else if (hit) clamp_q <= wr_data[W-1:0];
    end

    assign in_clamp[LO +: W] = clamp_q;
  end

endmodule

// File: rtl/xpt_ctl_slave.sv
module xpt_ctl_slave #(
  parameter int         NUM_IN      = 12,
  parameter int         NUM_OUT     = 9,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_LO      = 7'h03,
  parameter logic [6:0] DEV_HI      = 7'h43,
  parameter logic [7:0] OUT_BASE    = 8'h01,
  parameter logic [7:0] CLAMP_BASE  = 8'h1D
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_i,
  input  logic                      sda_i,
  input  logic                      addr_sel,
  output logic                      sda_oe,
  output logic [NUM_OUT-1:0]        out_en,
  output logic [2*NUM_OUT-1:0]      out_gain,
  output logic [NUM_OUT*NUM_IN-1:0] out_route,
  output logic [NUM_IN-1:0]         in_clamp
);

  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_det;
  logic       stop_det;
  logic       wr_en;
  logic [7:0] wr_ptr;
  logic [7:0] wr_data;

  xpt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  xpt_byte_engine #(.DEV_LO(DEV_LO), .DEV_HI(DEV_HI)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .addr_sel  (addr_sel),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .wr_data   (wr_data)
  );

  xpt_cfg_regs #(
    .NUM_IN     (NUM_IN),
    .NUM_OUT    (NUM_OUT),
    .OUT_BASE   (OUT_BASE),
    .CLAMP_BASE (CLAMP_BASE)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .wr_data   (wr_data),
    .out_en    (out_en),
    .out_gain  (out_gain),
    .out_route (out_route),
    .in_clamp  (in_clamp)
  );

endmodule

// File: rtl/xpt_ctl_checker.sv
module xpt_ctl_checker #(
  parameter int         NUM_IN     = 12,
  parameter int         NUM_OUT    = 9,
  parameter logic [7:0] OUT_BASE   = 8'h01,
  parameter logic [7:0] CLAMP_BASE = 8'h1D
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      scl_s,
  input logic                      sda_oe,
  input logic                      wr_en,
  input logic [7:0]                wr_ptr,
  input logic [NUM_OUT-1:0]        out_en,
  input logic [2*NUM_OUT-1:0]      out_gain,
  input logic [NUM_OUT*NUM_IN-1:0] out_route,
  input logic [NUM_IN-1:0]         in_clamp
);

  localparam int         CLAMP_BYTES = (NUM_IN + 7) / 8;
  localparam logic [8:0] OUT_LO      = {1'b0, OUT_BASE};
  localparam logic [8:0] OUT_END     = 9'(OUT_BASE + NUM_OUT);
  localparam logic [8:0] CL_LO       = {1'b0, CLAMP_BASE};
  localparam logic [8:0] CL_END      = 9'(CLAMP_BASE + CLAMP_BYTES);

  logic [8:0] ptr9;
  logic       ptr_defined;
  logic [NUM_OUT*(NUM_IN+3)+NUM_IN-1:0] all_ctl;

  assign ptr9        = {1'b0, wr_ptr};
  assign ptr_defined = ((ptr9 >= OUT_LO) && (ptr9 < OUT_END)) ||
                       ((ptr9 >= CL_LO)  && (ptr9 < CL_END));
  assign all_ctl     = {out_en, out_gain, out_route, in_clamp};

  // R1: the first edge out of reset sees every control cleared
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (all_ctl == '0) && !sda_oe);

  // R4: the acknowledge is only raised or dropped while SCL is low
  a_r4_ack_edges_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_s);

  // R9: a strobe to an undefined pointer leaves all controls unchanged
  a_r9_undef_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ptr_defined) |=> $stable(all_ctl));

  // R11: controls only move on a completed data byte
  a_r11_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(all_ctl));

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk
    // R6: at most one input per output
    a_r6_route_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_route[o*NUM_IN +: NUM_IN]));
    // R7: an output that is off routes nothing
    a_r7_off_routes_none: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en[o] |-> (out_route[o*NUM_IN +: NUM_IN] == '0));
  end

endmodule

bind xpt_ctl_slave xpt_ctl_checker #(
  .NUM_IN     (NUM_IN),
  .NUM_OUT    (NUM_OUT),
  .OUT_BASE   (OUT_BASE),
  .CLAMP_BASE (CLAMP_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .sda_oe    (sda_oe),
  .wr_en     (wr_en),
  .wr_ptr    (wr_ptr),
  .out_en    (out_en),
  .out_gain  (out_gain),
  .out_route (out_route),
  .in_clamp  (in_clamp)
);

// File: tb/tb_xpt_ctl_slave.sv
`timescale 1ns/1ps
module tb_xpt_ctl_slave;

  localparam int NI = 12;
  localparam int NO = 9;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic sda_line;
  logic sda_oe;
  logic [NO-1:0]    out_en;
  logic [2*NO-1:0]  out_gain;
  logic [NO*NI-1:0] out_route;
  logic [NI-1:0]    in_clamp;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  xpt_ctl_slave dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .addr_sel  (addr_sel),
    .sda_oe    (sda_oe),
    .out_en    (out_en),
    .out_gain  (out_gain),
    .out_route (out_route),
    .in_clamp  (in_clamp)
  );

  // Reference model: register contents as the requirements define them.
  logic [7:0]    m_ctl [NO];
  logic [NI-1:0] m_clamp;
  int  n_chk = 0;
  int  n_fail = 0;
  int  cyc = 0;
  bit  cmp_on = 1'b0;
  bit  finished = 1'b0;

  function automatic logic [NO-1:0] e_en();
    for (int o = 0; o < NO; o++) e_en[o] = m_ctl[o][7];
  endfunction

  function automatic logic [2*NO-1:0] e_gain();
    for (int o = 0; o < NO; o++) e_gain[2*o +: 2] = m_ctl[o][6:5];
  endfunction

  function automatic logic [NO*NI-1:0] e_route();
    e_route = '0;
    for (int o = 0; o < NO; o++) begin
      int code;
      code = int'(m_ctl[o][4:0]);
      if (m_ctl[o][7] && code >= 1 && code <= NI) e_route[o*NI + code - 1] = 1'b1;
    end
  endfunction

  task automatic model_write(logic [7:0] ptr, logic [7:0] data);
    if (ptr >= 8'h01 && ptr <= 8'h09) m_ctl[ptr - 8'h01] = data;
    else if (ptr == 8'h1D) m_clamp[7:0] = data;
    else if (ptr == 8'h1E) m_clamp[11:8] = data[3:0];
  endtask

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_state(string tag);
    chk(tag, "out_en",    128'(out_en),    128'(e_en()));
    chk(tag, "out_gain",  128'(out_gain),  128'(e_gain()));
    chk(tag, "out_route", 128'(out_route), 128'(e_route()));
    chk(tag, "in_clamp",  128'(in_clamp),  128'(m_clamp));
  endtask

  // Every-clock comparison against the model.
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R5", "out_en/clk",      128'(out_en),    128'(e_en()));
      chk("R5", "out_gain/clk",    128'(out_gain),  128'(e_gain()));
      chk("R6/R7", "out_route/clk", 128'(out_route), 128'(e_route()));
      chk("R8", "in_clamp/clk",    128'(in_clamp),  128'(m_clamp));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic hclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hclk(8);
    scl = 1'b1;   hclk(8);
    sda_m = 1'b0; hclk(8);
    scl = 1'b0;   hclk(8);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hclk(8);
    scl = 1'b1;   hclk(8);
    sda_m = 1'b1; hclk(8);
  endtask

  // One data bit; when commit is set the model takes the write at the
  // fourth clock edge after SCL rises (2 sync + strobe + register).
  task automatic send_bit(bit b, bit commit, logic [7:0] cptr, logic [7:0] cdata);
    sda_m = b; hclk(8);
    scl = 1'b1;
    if (commit) begin
      repeat (4) @(posedge clk);
      model_write(cptr, cdata);
      hclk(5);
    end else begin
      hclk(8);
    end
    scl = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b, bit exp_ack, string tag, bit commit, logic [7:0] cptr);
    for (int i = 7; i >= 0; i--) send_bit(b[i], commit && (i == 0), cptr, b);
    sda_m = 1'b1; hclk(8);
    scl = 1'b1;   hclk(4);
    chk(tag, "ack", 128'(sda_oe), 128'(exp_ack));
    hclk(4);
    scl = 1'b0;
  endtask

  // Full write transaction; the model decides from the address byte.
  task automatic wr_txn(logic [7:0] dev, logic [7:0] ptr, logic [7:0] data, int extra, string tag);
    bit hit;
    hit = (dev == (addr_sel ? 8'h86 : 8'h06));
    bus_start();
    send_byte(dev, hit, tag, 1'b0, 8'h00);
    send_byte(ptr, hit, tag, 1'b0, 8'h00);
    send_byte(data, hit, tag, hit, ptr);
    for (int e = 0; e < extra; e++) send_byte(8'hFF - 8'(e), hit, "R10", 1'b0, 8'h00);
    bus_stop();
  endtask

  initial begin
    for (int o = 0; o < NO; o++) m_ctl[o] = 8'h00;
    m_clamp = '0;
    hclk(6);
    rst_n = 1'b1;
    hclk(4);

    // R1: reset state
    check_state("R1");
    chk("R1", "sda_oe", 128'(sda_oe), 128'(0));
    cmp_on = 1'b1;

    // R5 R6: output 1 on, gain 01, input 3
    wr_txn(8'h06, 8'h01, 8'hA3, 0, "R4");
    hclk(4); check_state("R5");

    // R6: every output, a spread of codes, output 9 gets the top code 12
    for (int o = 2; o <= 9; o++) begin
      logic [7:0] d;
      d = 8'h80 | 8'((o % 4) << 5) | 8'((o == 9) ? 12 : o + 2);
      wr_txn(8'h06, 8'(o), d, 0, "R4");
    end
    hclk(4); check_state("R6");

    // R6: code 0, first unused code 13, and 31 route nothing
    wr_txn(8'h06, 8'h02, 8'hE0, 0, "R4");
    wr_txn(8'h06, 8'h03, 8'h8D, 0, "R4");
    wr_txn(8'h06, 8'h04, 8'h9F, 0, "R4");
    hclk(4); check_state("R6");

    // R7: output 1 off with a valid code still stored
    wr_txn(8'h06, 8'h01, 8'h63, 0, "R4");
    hclk(4); check_state("R7");

    // R8: clamp registers, high nibble of the second one ignored
    wr_txn(8'h06, 8'h1D, 8'hA5, 0, "R4");
    wr_txn(8'h06, 8'h1E, 8'hF9, 0, "R4");
    hclk(4); check_state("R8");

    // R9: undefined pointers
    wr_txn(8'h06, 8'h00, 8'hFF, 0, "R9");
    wr_txn(8'h06, 8'h0A, 8'hFF, 0, "R9");
    wr_txn(8'h06, 8'h1C, 8'hFF, 0, "R9");
    wr_txn(8'h06, 8'h1F, 8'hFF, 0, "R9");
    wr_txn(8'h06, 8'hFF, 8'h00, 0, "R9");
    hclk(4); check_state("R9");

    // R10: trailing bytes acknowledged, not stored
    wr_txn(8'h06, 8'h05, 8'hC1, 3, "R10");
    hclk(4); check_state("R10");

    // R2: other strap's address ignored while strap is low
    wr_txn(8'h86, 8'h06, 8'hFF, 0, "R2");
    hclk(4); check_state("R2");
    addr_sel = 1'b1;
    wr_txn(8'h86, 8'h06, 8'hEC, 0, "R2");
    wr_txn(8'h06, 8'h07, 8'hFF, 0, "R2");
    hclk(4); check_state("R2");

    // R3: read request refused, later bytes ignored until START
    wr_txn(8'h87, 8'h08, 8'hFF, 1, "R3");
    hclk(4); check_state("R3");
    chk("R3", "sda_oe idle", 128'(sda_oe), 128'(0));

    // R11: STOP halfway through the data byte
    bus_start();
    send_byte(8'h86, 1'b1, "R11", 1'b0, 8'h00);
    send_byte(8'h06, 1'b1, "R11", 1'b0, 8'h00);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0, 8'h00, 8'h00);
    bus_stop();
    hclk(4); check_state("R11");

    // R11: repeated START drops the first pointer
    bus_start();
    send_byte(8'h86, 1'b1, "R11", 1'b0, 8'h00);
    send_byte(8'h07, 1'b1, "R11", 1'b0, 8'h00);
    bus_start();
    send_byte(8'h86, 1'b1, "R11", 1'b0, 8'h00);
    send_byte(8'h08, 1'b1, "R11", 1'b0, 8'h00);
    send_byte(8'hA2, 1'b1, "R11", 1'b1, 8'h08);
    bus_stop();
    hclk(4); check_state("R11");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule